// File: doc/BRIEF.md
# Write-Only Configuration Register Slave on a Two-Wire Serial Bus

This block is a slave on a two-wire serial control bus (I2C). It accepts write transfers only and uses them to load three configuration registers that set up a stereo converter: an 8-bit sample-rate and frame-format register, a 16-bit volume register and an 8-bit global configuration register. The two bus lines are brought into the system clock domain through a flop synchroniser. START and STOP conditions are recognised as data-line edges while the clock line is high. The block pulls the data line low only to acknowledge a byte, so the pad works as open drain.

A transfer is the device address byte, then a subaddress byte, then one or two data bytes. The subaddress carries a 2-bit chip select in its top two bits and a 2-bit register index in its bottom two bits. The chip select must match the two strap pins, so up to four of these blocks can share one bus. When both straps are high the block runs in an automatic-rate mode: it answers chip select 3, and the low three bits of the sample-rate register always read back as the autoselect code.

After reset all registers are zero. One clock after reset is released, an automatic initialisation step loads their defaults. A register changes only after the ACK of its last byte, and it changes as a whole.

Top module: `i2c_cfg_slave`

## Requirements
- R1: While rst_n is low, rate_reg, vol_reg and gcfg_reg are all zero and sda_oe is low (straps at 0).
- R2: Within three clock cycles after rst_n rises, the registers hold their defaults: vol_reg = 0x2C2C, gcfg_reg = 0x04, rate_reg = 0x00.
- R3: The address byte 0x9A (7-bit address 1001101, write) is ACKed, meaning the block pulls SDA low during the ninth clock. Any other address byte, including the read form 0x9B, is NACKed, and every later byte up to STOP is NACKed and ignored.
- R4: A subaddress byte is ACKed only when its bits 7:6 equal {cs_strap[1], cs_strap[0]} and its bits 1:0 are non-zero; bits 5:2 are ignored. On a mismatch or index 0 the byte is NACKed and the rest of the transfer is ignored, with all registers unchanged.
- R5: Index 1 writes one byte into rate_reg, and index 3 writes one byte into gcfg_reg. Each data byte is ACKed.
- R6: Index 2 writes vol_reg from two ACKed bytes, the first byte going to bits 15:8. vol_reg changes only after the second byte is ACKed.
- R7: A volume write cut short by STOP after its first data byte leaves vol_reg unchanged.
- R8: Data bytes beyond the width of the selected register are NACKed and not written.
- R9: With cs_strap = 2'b11, rate_auto is 1 and rate_reg[2:0] reads 3'b110 whatever was written, while rate_reg[7:3] follow writes. In any other strap setting rate_auto is 0 and rate_reg shows the stored value.
- R10: sda_oe is raised only while SCL is low, and it is held for the acknowledge clock only.
- R11: A repeated START in the middle of a transfer restarts address decoding and discards any partial volume write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull data line low when 1 (open-drain enable) |
| cs_strap | input | 2 | Chip-select straps; 2'b11 selects automatic-rate mode |
| rate_reg | output | 8 | Sample-rate/format register, with the rate field forced in automatic mode |
| vol_reg | output | 16 | Volume register, left level in the upper byte |
| gcfg_reg | output | 8 | Global configuration register |
| rate_auto | output | 1 | High when the sample-rate field is forced to autoselect |

## Verification
A wrong protocol state shows at the ports first as a wrong acknowledge level on the ninth clock of the byte where the state went wrong. An ACK where a NACK was due, or the reverse, is therefore visible within one byte time. A wrong byte counter or staging error shows only as a wrong register value after STOP, so each transfer is followed by a full snapshot of all three registers. Partial, overlong and restarted volume writes are run because they are the cases where a staging fault would otherwise go unnoticed.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_SUB, ST_DATA, ST_IGNORE} i2c_st_e;
  localparam logic [BYTE_W-1:0] DEV_WR_ADDR  = 8'h9A;
  localparam logic [1:0]        IDX_RATE     = 2'd1;
  localparam logic [1:0]        IDX_VOL      = 2'd2;
  localparam logic [1:0]        IDX_GCFG     = 2'd3;
  localparam logic [1:0]        CS_AUTO      = 2'b11;
  localparam logic [2:0]        AUTO_CODE    = 3'b110;
  localparam logic [WORD_W-1:0] VOL_DEFAULT  = 16'h2C2C;
  localparam logic [BYTE_W-1:0] GCFG_DEFAULT = 8'h04;
  localparam logic [BYTE_W-1:0] RATE_DEFAULT = 8'h00;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [1:0]        chip_id,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [1:0]        wr_idx,
  output logic [WORD_W-1:0] wr_data
);
  localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

  i2c_st_e           state;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] hi_byte;
  logic [3:0]        bit_cnt;
  logic              ack_ph;
  logic              ack_ok;
  logic [1:0]        idx;
  logic [1:0]        nbyte;
  logic              take;
  logic              last;

  always_comb begin
    take = 1'b0;
    unique case (state)
      ST_ADDR: take = (sh == DEV_WR_ADDR);
      ST_SUB:  take = (sh[7:6] == chip_id) && (sh[1:0] != 2'd0);
      ST_DATA: take = (idx == IDX_VOL) ? (nbyte < 2'd2) : (nbyte < 2'd1);
      default: take = 1'b0;
    endcase
  end

  assign last = (idx == IDX_VOL) ? (nbyte == 2'd1) : (nbyte == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sh       <= '0;
      hi_byte  <= '0;
      bit_cnt  <= '0;
      ack_ph   <= 1'b0;
      ack_ok   <= 1'b0;
      idx      <= '0;
      nbyte    <= '0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_evt) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        ack_ph  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE && state != ST_IGNORE) begin
        if (scl_rise && !ack_ph) begin
          sh      <= {sh[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall) begin
          if (ack_ph) begin
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
            if (!ack_ok) begin
              state <= ST_IGNORE;
            end else begin
              unique case (state)
                ST_ADDR: state <= ST_SUB;
                ST_SUB: begin
                  state <= ST_DATA;
                  idx   <= sh[1:0];
                  nbyte <= '0;
                end
                ST_DATA: begin
                  nbyte <= nbyte + 2'd1;
                  if (last) begin
                    wr_valid <= 1'b1;
                    wr_idx   <= idx;
                    wr_data  <= (idx == IDX_VOL) ? {hi_byte, sh} : {{BYTE_W{1'b0}}, sh};
                  end else begin
                    hi_byte <= sh;
                  end
                end
                default: state <= ST_IGNORE;
              endcase
            end
          end else if (bit_cnt == BITS_PER_BYTE) begin
            ack_ph  <= 1'b1;
            bit_cnt <= '0;
            ack_ok  <= take;
            sda_oe  <= take;
          end
        end
      end
    end
  end

  // R10
  oe_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe);

  // R6
  commit_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (state == ST_DATA));
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
  import i2c_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [1:0]        wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              auto_mode,
  output logic [BYTE_W-1:0] rate_reg,
  output logic [WORD_W-1:0] vol_reg,
  output logic [BYTE_W-1:0] gcfg_reg
);
  logic [BYTE_W-1:0] rate_q, gcfg_q;
  logic [WORD_W-1:0] vol_q;
  logic              init_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q    <= '0;
      vol_q     <= '0;
      gcfg_q    <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      rate_q    <= RATE_DEFAULT;
      vol_q     <= VOL_DEFAULT;
      gcfg_q    <= GCFG_DEFAULT;
      init_done <= 1'b1;
    end else if (wr_valid) begin
      unique case (wr_idx)
        IDX_RATE: rate_q <= wr_data[BYTE_W-1:0];
        IDX_VOL:  vol_q  <= wr_data;
        IDX_GCFG: gcfg_q <= wr_data[BYTE_W-1:0];
        default:  ;
      endcase
    end
  end

  assign rate_reg = auto_mode ? {rate_q[BYTE_W-1:3], AUTO_CODE} : rate_q;
  assign vol_reg  = vol_q;
  assign gcfg_reg = gcfg_q;

  // R7
  vol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !(wr_valid && wr_idx == IDX_VOL)) |=> $stable(vol_q));

  // R5
  gcfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !(wr_valid && wr_idx == IDX_GCFG)) |=> $stable(gcfg_q));
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        cs_strap,
  output logic [BYTE_W-1:0] rate_reg,
  output logic [WORD_W-1:0] vol_reg,
  output logic [BYTE_W-1:0] gcfg_reg,
  output logic              rate_auto
);
  logic scl_s, sda_s, start_evt, stop_evt, scl_rise, scl_fall;
  logic              wr_valid;
  logic [1:0]        wr_idx;
  logic [WORD_W-1:0] wr_data;

  assign rate_auto = (cs_strap == CS_AUTO);

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c_wr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .chip_id(cs_strap), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  i2c_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
    .auto_mode(rate_auto), .rate_reg(rate_reg), .vol_reg(vol_reg), .gcfg_reg(gcfg_reg)
  );

  // R9
  auto_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_strap == CS_AUTO) |-> (rate_reg[2:0] == AUTO_CODE && rate_auto));
endmodule

// File: tb/tb_i2c_cfg_slave.sv
module tb_i2c_cfg_slave;
  localparam int HB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        tb_sda = 1'b1;
  logic [1:0]  cs = 2'b00;
  logic        sda_line;
  logic        sda_oe, rate_auto;
  logic [7:0]  rate_reg, gcfg_reg;
  logic [15:0] vol_reg;

  int errs = 0;
  int checks = 0;

  logic [7:0]  m_rate;
  logic [15:0] m_vol;
  logic [7:0]  m_gcfg;

  typedef struct {
    string       tag;
    logic [7:0]  rate;
    logic [15:0] vol;
    logic [7:0]  gcfg;
    logic        auto_f;
  } snap_t;
  snap_t exp_q[$];

  always #2.5 clk = ~clk;
  assign sda_line = tb_sda & ~sda_oe;

  i2c_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .cs_strap(cs), .rate_reg(rate_reg), .vol_reg(vol_reg), .gcfg_reg(gcfg_reg),
    .rate_auto(rate_auto)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hold();
    repeat (HB) @(negedge clk);
  endtask

  task automatic bus_start();
    tb_sda = 1'b1; hold();
    scl = 1'b1; hold();
    tb_sda = 1'b0; hold();
    scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    tb_sda = 1'b0; hold();
    scl = 1'b1; hold();
    tb_sda = 1'b1; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      tb_sda = b[i]; hold();
      scl = 1'b1; hold();
      scl = 1'b0; hold();
    end
    tb_sda = 1'b1; hold();
    scl = 1'b1;
    repeat (HB/2) @(negedge clk);
    acked = ~sda_line;
    repeat (HB/2) @(negedge clk);
    scl = 1'b0; hold();
  endtask

  // send n bytes after START; exp_ack[i] is the expected ACK for byte i
  task automatic bytes_out(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                           input logic [7:0] b3, input int n, input logic [3:0] exp_ack, input string req);
    logic [7:0] bl [4];
    logic a;
    bl[0] = b0; bl[1] = b1; bl[2] = b2; bl[3] = b3;
    for (int i = 0; i < n; i++) begin
      send_byte(bl[i], a);
      chk(req, $sformatf("ack of byte %0d", i), {31'b0, a}, {31'b0, exp_ack[i]});
    end
  endtask

  task automatic expect_regs(input string tag);
    snap_t s;
    s.tag    = tag;
    s.rate   = (cs == 2'b11) ? {m_rate[7:3], 3'b110} : m_rate;
    s.vol    = m_vol;
    s.gcfg   = m_gcfg;
    s.auto_f = (cs == 2'b11);
    exp_q.push_back(s);
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  // monitor: pops expected snapshots and compares against the outputs
  initial begin
    forever begin
      snap_t e;
      wait (exp_q.size() != 0);
      @(negedge clk);
      e = exp_q.pop_front();
      chk(e.tag, "rate_reg", {24'b0, rate_reg}, {24'b0, e.rate});
      chk(e.tag, "vol_reg", {16'b0, vol_reg}, {16'b0, e.vol});
      chk(e.tag, "gcfg_reg", {24'b0, gcfg_reg}, {24'b0, e.gcfg});
      chk(e.tag, "rate_auto", {31'b0, rate_auto}, {31'b0, e.auto_f});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1", "rate_reg", {24'b0, rate_reg}, 32'h0);
    chk("R1", "vol_reg", {16'b0, vol_reg}, 32'h0);
    chk("R1", "gcfg_reg", {24'b0, gcfg_reg}, 32'h0);
    chk("R1", "sda_oe", {31'b0, sda_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_rate = 8'h00; m_vol = 16'h2C2C; m_gcfg = 8'h04;
    expect_regs("R2");

    // R3 R5: rate write
    bus_start(); bytes_out(8'h9A, 8'h01, 8'h1B, 8'h00, 3, 4'b0111, "R5"); bus_stop();
    m_rate = 8'h1B; expect_regs("R5");
    bus_start(); bytes_out(8'h9A, 8'h03, 8'h37, 8'h00, 3, 4'b0111, "R5"); bus_stop();
    m_gcfg = 8'h37; expect_regs("R5");

    // R6: volume, upper byte first
    bus_start(); bytes_out(8'h9A, 8'h02, 8'h12, 8'h34, 4, 4'b1111, "R6"); bus_stop();
    m_vol = 16'h1234; expect_regs("R6");

    // R7: partial volume write
    bus_start(); bytes_out(8'h9A, 8'h02, 8'h55, 8'h00, 3, 4'b0111, "R7"); bus_stop();
    expect_regs("R7");

    // R3: read form and foreign address NACKed, rest ignored
    bus_start(); bytes_out(8'h9B, 8'h01, 8'hFF, 8'h00, 3, 4'b0000, "R3"); bus_stop();
    expect_regs("R3");
    bus_start(); bytes_out(8'h9C, 8'h03, 8'hFF, 8'h00, 3, 4'b0000, "R3"); bus_stop();
    expect_regs("R3");

    // R4: chip select mismatch, index 0
    bus_start(); bytes_out(8'h9A, 8'h41, 8'h00, 8'h00, 3, 4'b0001, "R4"); bus_stop();
    expect_regs("R4");
    bus_start(); bytes_out(8'h9A, 8'h00, 8'h99, 8'h00, 3, 4'b0001, "R4"); bus_stop();
    expect_regs("R4");

    // R8: overlong writes
    bus_start(); bytes_out(8'h9A, 8'h01, 8'h22, 8'h33, 4, 4'b0111, "R8"); bus_stop();
    m_rate = 8'h22; expect_regs("R8");
    bus_start(); bytes_out(8'h9A, 8'h02, 8'hAA, 8'hBB, 4, 4'b1111, "R8");
    bytes_out(8'hCC, 8'h00, 8'h00, 8'h00, 1, 4'b0000, "R8"); bus_stop();
    m_vol = 16'hAABB; expect_regs("R8");

    // R11: repeated start discards partial volume write
    bus_start(); bytes_out(8'h9A, 8'h02, 8'h77, 8'h00, 3, 4'b0111, "R11");
    bus_start(); bytes_out(8'h9A, 8'h03, 8'h0F, 8'h00, 3, 4'b0111, "R11"); bus_stop();
    m_gcfg = 8'h0F; expect_regs("R11");

    // R4: straps 2
    cs = 2'b10; hold();
    bus_start(); bytes_out(8'h9A, 8'h81, 8'h44, 8'h00, 3, 4'b0111, "R4"); bus_stop();
    m_rate = 8'h44; expect_regs("R4");
    bus_start(); bytes_out(8'h9A, 8'h01, 8'h55, 8'h00, 3, 4'b0001, "R4"); bus_stop();
    expect_regs("R4");

    // R9: automatic mode forces rate field
    cs = 2'b11; hold();
    expect_regs("R9");
    bus_start(); bytes_out(8'h9A, 8'hC1, 8'hA8, 8'h00, 3, 4'b0111, "R9"); bus_stop();
    m_rate = 8'hA8; expect_regs("R9");
    // R4: bits 5:2 of the subaddress ignored
    bus_start(); bytes_out(8'h9A, 8'hFF, 8'h5A, 8'h00, 3, 4'b0111, "R4"); bus_stop();
    m_gcfg = 8'h5A; expect_regs("R4");
    cs = 2'b00; hold();
    expect_regs("R9");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule